// File: doc/BRIEF.md
# ATS Translation Response Address Composer

This block sits on the root-complex side of an address translation service path. It records each outgoing translation request, with its input address, its substream-valid flag and its tag, in a small table indexed by tag. When the translation agent answers, the block looks up the request by tag and builds the final translated address. The address is put together from the low bits of the stored input address and the high bits of the response output address. The split point comes from the response size code, or from the bypass flag.

The block also checks the bypass and global flags against the rules for them. It then presents a completion-style result that carries the translated address, a global flag and an error bit. A response whose tag has no outstanding request produces no result. It raises a one-cycle tag error pulse instead.

The control is a two-state machine. In `ST_WAIT_RSP` the block accepts a response. On a response that hits an outstanding tag it takes the transition `hit` to `ST_HOLD_RES`. A response that misses takes the transition `miss` and stays in `ST_WAIT_RSP`. In `ST_HOLD_RES` the result is held until the consumer takes it, and the transition `drain` returns to `ST_WAIT_RSP`.

Top module: `ats_xlat_composer`

## Requirements
- R1: A request is accepted only when its tag has no outstanding request. `req_ready` is low while the tag presented on `req_tag` is outstanding and high while it is free.
- R2: A response whose tag is not outstanding is consumed. It raises `tag_err` for exactly one cycle, in the cycle after acceptance, and does not raise `out_valid`.
- R3: With bypass 0, the size code r gives a granule of 2^(12+r) bytes. `out_addr` takes the input-address bits below that granule and the response-address bits above it. When 12+r reaches the address width, the whole input address is used.
- R4: With bypass 1 and no error, `out_addr` equals the stored input address, whatever the response output address holds (it may be zero).
- R5: With bypass 1, an input address at or above 2^`oas_bits` gives `out_err` = 1.
- R6: When the request had substream-valid 0, a response with global 1 gives `out_err` = 1.
- R7: With parameter STRICT_G = 1, a response with bypass 1 and global 0 to a request with substream-valid 1 gives `out_err` = 1.
- R8: `out_global` is 1 only when the request had substream-valid 1, the response global is 1, there is no error and `force_g_zero` is 0. With `force_g_zero` = 1 it is always 0.
- R9: When `out_err` is 1, `out_addr` is zero and `out_global` is 0.
- R10: The result is valid in the cycle after the response is accepted. It holds stable while `out_ready` is low, and `rsp_ready` stays low until the result is taken.
- R11: Once a response hits, its tag is free again and `req_ready` for that tag returns high.
- R12: After reset, no tag is outstanding, `out_valid` and `tag_err` are 0, and `rsp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oas_bits | input | OAS_W | Static supported output-address width in bits |
| force_g_zero | input | 1 | Mode: report global as 0 always |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request tag free, request accepted |
| req_tag | input | TAG_W | Request tag |
| req_addr | input | AW | Request input address |
| req_ssv | input | 1 | Request substream-valid flag |
| rsp_valid | input | 1 | Translation response valid |
| rsp_ready | output | 1 | Block can take a response |
| rsp_tag | input | TAG_W | Response tag |
| rsp_oaddr | input | AW | Response output address |
| rsp_range | input | RANGE_W | Response size code r, granule 2^(12+r) |
| rsp_bypass | input | 1 | Response bypass flag (1 = translation bypassed) |
| rsp_global | input | 1 | Response global flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_tag | output | TAG_W | Tag of the result |
| out_addr | output | AW | Composed translated address |
| out_global | output | 1 | Normalised global flag |
| out_err | output | 1 | Response violated a bypass/global rule |
| tag_err | output | 1 | One-cycle pulse: response with an idle tag |

## Verification
The bench sweeps every size code, including codes that carry the granule past the address width. A design with an off-by-one split point, or one that fails to saturate the mask, would mix the wrong bits of the two addresses. Bypass responses use a zero output address and input addresses on both sides of the supported width. A design that passes the response address through, or that compares against the width wrongly, would return zero or miss the error. All four substream-valid and global pairings are driven with and without the force mode, which catches a reserved global bit that leaks out or a strict-rule check that is missing. Idle-tag responses, back-pressure on the result and tag reuse are exercised to catch phantom results, unstable held data and tags that never free.

// File: rtl/ats_comp_pkg.sv
package ats_comp_pkg;
    typedef enum logic [0:0] {
        ST_WAIT_RSP = 1'b0,
        ST_HOLD_RES = 1'b1
    } comp_state_e;

    localparam int GRANULE_SHIFT = 12;
endpackage

// File: rtl/ats_req_table.sv
module ats_req_table #(
    parameter int AW    = 48,
    parameter int TAGS  = 8,
    parameter int TAG_W = $clog2(TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [AW-1:0]    wr_addr,
    input  logic             wr_ssv,
    input  logic             free_en,
    input  logic [TAG_W-1:0] free_tag,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_busy,
    output logic [AW-1:0]    rd_addr,
    output logic             rd_ssv,
    input  logic [TAG_W-1:0] chk_tag,
    output logic             chk_busy
);
    logic [TAGS-1:0] busy_vec;
    logic [TAGS-1:0] ssv_vec;
    logic [AW-1:0]   addr_arr [TAGS];

    for (genvar g = 0; g < TAGS; g++) begin : g_entry
        logic          busy_r;
        logic          ssv_r;
        logic [AW-1:0] addr_r;
        logic          set_me;
        logic          clr_me;

        assign set_me = wr_en   && (wr_tag   == TAG_W'(g));
        assign clr_me = free_en && (free_tag == TAG_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                busy_r <= 1'b0;
                ssv_r  <= 1'b0;
                addr_r <= '0;
            end else if (set_me) begin
                busy_r <= 1'b1;
                ssv_r  <= wr_ssv;
                addr_r <= wr_addr;
            end else if (clr_me) begin
                busy_r <= 1'b0;
            end
        end

        assign busy_vec[g] = busy_r;
        assign ssv_vec[g]  = ssv_r;
        assign addr_arr[g] = addr_r;
    end

    assign rd_busy  = busy_vec[rd_tag];
    assign rd_ssv   = ssv_vec[rd_tag];
    assign rd_addr  = addr_arr[rd_tag];
    assign chk_busy = busy_vec[chk_tag];

    AST_SET_IDLE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy_vec[wr_tag]); // R1
    AST_FREE_HELD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |=> !busy_vec[$past(free_tag)]); // R11
endmodule

// File: rtl/ats_addr_splice.sv
module ats_addr_splice
    import ats_comp_pkg::*;
#(
    parameter int AW       = 48,
    parameter int RANGE_W  = 5,
    parameter int OAS_W    = 7,
    parameter bit STRICT_G = 1'b1
) (
    input  logic [AW-1:0]      in_addr,
    input  logic               in_ssv,
    input  logic [AW-1:0]      oaddr,
    input  logic [RANGE_W-1:0] range_code,
    input  logic               bypass,
    input  logic               glob,
    input  logic [OAS_W-1:0]   oas_bits,
    input  logic               force_g,
    output logic [AW-1:0]      res_addr,
    output logic               res_global,
    output logic               res_err
);
    int          split_pos;
    logic [AW-1:0] low_mask;
    logic        oas_over;
    logic        strict_bad;
    logic        reserved_bad;
    logic [AW-1:0] spliced;

    always_comb begin
        split_pos = GRANULE_SHIFT + int'(range_code);
        if (split_pos >= AW) begin
            low_mask = '1;
        end else begin
            low_mask = (AW'(1) << split_pos) - AW'(1);
        end
    end

    always_comb begin
        if (int'(oas_bits) >= AW) begin
            oas_over = 1'b0;
        end else begin
            oas_over = (in_addr >> oas_bits) != '0;
        end
    end

    if (STRICT_G) begin : g_strict
        assign strict_bad = in_ssv && bypass && !glob;
    end else begin : g_relaxed
        assign strict_bad = 1'b0;
    end

    assign reserved_bad = !in_ssv && glob;
    assign res_err      = (bypass && oas_over) || reserved_bad || strict_bad;
    assign spliced      = (oaddr & ~low_mask) | (in_addr & low_mask);

    always_comb begin
        if (res_err) begin
            res_addr = '0;
        end else if (bypass) begin
            res_addr = in_addr;
        end else begin
            res_addr = spliced;
        end
    end

    assign res_global = !res_err && in_ssv && glob && !force_g;
endmodule

// File: rtl/ats_xlat_composer.sv
module ats_xlat_composer
    import ats_comp_pkg::*;
#(
    parameter int AW       = 48,
    parameter int TAGS     = 8,
    parameter int RANGE_W  = 5,
    parameter int OAS_W    = 7,
    parameter bit STRICT_G = 1'b1,
    localparam int TAG_W   = $clog2(TAGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OAS_W-1:0]   oas_bits,
    input  logic               force_g_zero,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [AW-1:0]      req_addr,
    input  logic               req_ssv,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [TAG_W-1:0]   rsp_tag,
    input  logic [AW-1:0]      rsp_oaddr,
    input  logic [RANGE_W-1:0] rsp_range,
    input  logic               rsp_bypass,
    input  logic               rsp_global,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [TAG_W-1:0]   out_tag,
    output logic [AW-1:0]      out_addr,
    output logic               out_global,
    output logic               out_err,
    output logic               tag_err
);
    comp_state_e state_q, state_d;

    logic          rsp_fire, hit, miss, req_fire;
    logic          rd_busy, rd_ssv, chk_busy;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] calc_addr;
    logic          calc_global, calc_err;

    assign rsp_ready = (state_q == ST_WAIT_RSP);
    assign rsp_fire  = rsp_valid && rsp_ready;
    assign hit       = rsp_fire && rd_busy;
    assign miss      = rsp_fire && !rd_busy;
    assign req_ready = !chk_busy;
    assign req_fire  = req_valid && req_ready;
    assign out_valid = (state_q == ST_HOLD_RES);

    ats_req_table #(.AW(AW), .TAGS(TAGS), .TAG_W(TAG_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (req_fire),
        .wr_tag   (req_tag),
        .wr_addr  (req_addr),
        .wr_ssv   (req_ssv),
        .free_en  (hit),
        .free_tag (rsp_tag),
        .rd_tag   (rsp_tag),
        .rd_busy  (rd_busy),
        .rd_addr  (rd_addr),
        .rd_ssv   (rd_ssv),
        .chk_tag  (req_tag),
        .chk_busy (chk_busy)
    );

    ats_addr_splice #(.AW(AW), .RANGE_W(RANGE_W), .OAS_W(OAS_W), .STRICT_G(STRICT_G)) u_splice (
        .in_addr    (rd_addr),
        .in_ssv     (rd_ssv),
        .oaddr      (rsp_oaddr),
        .range_code (rsp_range),
        .bypass     (rsp_bypass),
        .glob       (rsp_global),
        .oas_bits   (oas_bits),
        .force_g    (force_g_zero),
        .res_addr   (calc_addr),
        .res_global (calc_global),
        .res_err    (calc_err)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_RSP;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: hit, miss, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_RSP: if (hit)       state_d = ST_HOLD_RES;
            ST_HOLD_RES: if (out_ready) state_d = ST_WAIT_RSP;
            default:                    state_d = ST_WAIT_RSP;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_tag    <= '0;
            out_addr   <= '0;
            out_global <= 1'b0;
            out_err    <= 1'b0;
            tag_err    <= 1'b0;
        end else begin
            tag_err <= miss;
            if (hit) begin
                out_tag    <= rsp_tag;
                out_addr   <= calc_addr;
                out_global <= calc_global;
                out_err    <= calc_err;
            end
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_global) && $stable(out_err)); // R10
    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tag_err |-> !out_valid); // R2
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_addr == '0 && !out_global); // R9
endmodule

// File: tb/test_ats_xlat_composer.sv
module test_ats_xlat_composer;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 20;
    localparam int TAGS  = 4;
    localparam int TW    = 2;
    localparam int RW    = 4;
    localparam int OW    = 7;
    localparam int OAS   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [OW-1:0] oas_bits = OW'(OAS);
    logic          force_g_zero = 1'b0;
    logic          req_valid = 1'b0, req_ssv = 1'b0;
    logic [TW-1:0] req_tag = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid = 1'b0, rsp_bypass = 1'b0, rsp_global = 1'b0;
    logic [TW-1:0] rsp_tag = '0;
    logic [AW-1:0] rsp_oaddr = '0;
    logic [RW-1:0] rsp_range = '0;
    logic          rsp_ready;
    logic          out_valid, out_global, out_err, tag_err;
    logic          out_ready = 1'b0;
    logic [TW-1:0] out_tag;
    logic [AW-1:0] out_addr;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    longint lcg = 64'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    ats_xlat_composer #(.AW(AW), .TAGS(TAGS), .RANGE_W(RW), .OAS_W(OW), .STRICT_G(1'b1)) i_ats_xlat_composer (
        .clk(clk), .rst_n(rst_n), .oas_bits(oas_bits), .force_g_zero(force_g_zero),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .req_addr(req_addr), .req_ssv(req_ssv),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
        .rsp_oaddr(rsp_oaddr), .rsp_range(rsp_range), .rsp_bypass(rsp_bypass),
        .rsp_global(rsp_global),
        .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
        .out_addr(out_addr), .out_global(out_global), .out_err(out_err),
        .tag_err(tag_err)
    );

    task automatic chk(input string rq, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    function automatic longint next_rand();
        lcg = (lcg * 64'd6364136223846793005 + 64'd1442695040888963407);
        return (lcg >>> 24) & 64'hF_FFFF;
    endfunction

    // tasks start and end just after a falling edge
    task automatic send_req(input int tag, input longint addr, input bit ssv);
        req_valid = 1'b1; req_tag = TW'(tag); req_addr = AW'(addr); req_ssv = ssv;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_rsp(input int tag, input longint oa, input int rg, input bit byp, input bit g);
        rsp_valid = 1'b1; rsp_tag = TW'(tag); rsp_oaddr = AW'(oa);
        rsp_range = RW'(rg); rsp_bypass = byp; rsp_global = g;
        @(posedge clk); @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic drain();
        out_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        out_ready = 1'b0;
    endtask

    function automatic longint exp_addr(longint in_a, longint oa, int rg, bit byp);
        longint gran;
        if (byp || (12 + rg >= AW)) return in_a;
        gran = 64'd1 << (12 + rg);
        return (oa - (oa % gran)) + (in_a % gran);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 out_valid", out_valid, 0);
        chk("R12 tag_err", tag_err, 0);
        chk("R12 rsp_ready", rsp_ready, 1);
        for (int t = 0; t < TAGS; t++) begin
            req_tag = TW'(t);
            #1 chk("R12 req_ready", req_ready, 1);
        end

        // R1 / R11: tag occupancy
        send_req(1, 20'h1_2345, 1'b1);
        req_tag = 2'd1; #1 chk("R1 busy tag blocks", req_ready, 0);
        req_tag = 2'd2; #1 chk("R1 free tag open", req_ready, 1);
        send_rsp(1, 20'hA_B000, 0, 1'b0, 1'b0);
        chk("R10 valid after one cycle", out_valid, 1);
        chk("R10 tag", out_tag, 1);
        chk("R3 splice r0", out_addr, 20'hA_B345);
        req_tag = 2'd1; #1 chk("R11 tag freed", req_ready, 1);
        drain();
        chk("R10 drained", out_valid, 0);

        // R2: idle tag
        send_rsp(3, 20'h5_5000, 0, 1'b0, 1'b0);
        chk("R2 tag_err pulse", tag_err, 1);
        chk("R2 no result", out_valid, 0);
        @(negedge clk);
        chk("R2 pulse one cycle", tag_err, 0);
        chk("R2 still no result", out_valid, 0);

        // R10: back-pressure
        send_req(0, 20'h0_0ABC, 1'b1);
        send_rsp(0, 20'hF_F000, 2, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 held valid", out_valid, 1);
            chk("R10 held addr", out_addr, 20'hF_CABC);
            chk("R10 rsp blocked", rsp_ready, 0);
        end
        drain();
        chk("R10 rsp open", rsp_ready, 1);

        // R3..R9 sweep
        for (int rg = 0; rg < 16; rg++) begin
            for (int byp = 0; byp < 2; byp++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int g = 0; g < 2; g++) begin
                        longint in_a, oa, ea;
                        bit eerr, eg;
                        int tag;
                        tag = (rg + g) % TAGS;
                        force_g_zero = (rg >= 12);
                        in_a = next_rand();
                        if ((rg % 2) == 0) in_a = in_a % (64'd1 << OAS);
                        else in_a = in_a | (64'd1 << OAS);
                        oa = byp ? 0 : next_rand();
                        eerr = (byp && in_a >= (64'd1 << OAS)) || (!s && g) || (s && byp && !g);
                        ea = eerr ? 0 : exp_addr(in_a, oa, rg, byp[0]);
                        eg = !eerr && s && g && !force_g_zero;
                        send_req(tag, in_a, s[0]);
                        send_rsp(tag, oa, rg, byp[0], g[0]);
                        chk("R10 sweep valid", out_valid, 1);
                        if (eerr) chk("R9 err addr zero", out_addr, 0);
                        else if (byp) chk("R4 bypass addr", out_addr, ea);
                        else chk("R3 splice addr", out_addr, ea);
                        if (byp && !s) chk("R6 reserved global", out_err, eerr);
                        else if (byp && s && !g) chk("R7 strict global", out_err, eerr);
                        else if (byp) chk("R5 oas check", out_err, eerr);
                        else chk("R6 err flag", out_err, eerr);
                        chk("R8 global", out_global, eg);
                        drain();
                    end
                end
            end
        end
        force_g_zero = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule